// File: doc/BRIEF.md
# Filter Coefficient RAM Staging Interface

This block sits between a byte-wide host register port and the coefficient store of an audio filter datapath. The host never touches the coefficient RAM directly. It loads a coefficient address and a bank of fifteen staging bytes, then writes a control byte. The command bit in that byte either pushes staged data into the RAM or pulls RAM contents back into staging, for one 24-bit coefficient or for a five-coefficient biquad set.

A biquad set is committed in a single clock edge. While that edge is pending, the datapath read port deasserts its ready, so a filter fetch can only ever see the complete old set or the complete new set. Each command runs in the cycle after the control write, and a busy flag covers exactly that cycle. A block command whose five entries would run past the top of the RAM is dropped and raises an error flag.

Top module: `coef_stage_top`

## Requirements
- R1: After reset, every RAM entry reads 0 except entries 50 through 55, which read 0x7FFFFF (unity gain). The staging bytes, the address register, the control register and the status register all read 0.
- R2: The host map is as follows. Addresses 0 to 14 are the staging bytes. The coefficient address register is at 16, the control register at 17 and the status register at 18. In status, bit 0 is busy and bit 1 is error. Any other host address reads 0. Coefficient k of a transfer occupies staging bytes 3k, 3k+1 and 3k+2, most significant byte first, and maps to RAM entry base+k. For a biquad the coefficient order is b1, b2, a1, a2, b0.
- R3: Control bit 0 writes the word held in staging bytes 0 to 2 into the RAM entry selected by the address register.
- R4: Control bit 1 writes staging coefficients 0 to 4 into RAM entries base to base+4, all on the same clock edge. RAM entries change only through bit 0 or bit 1.
- R5: Control bit 2 copies RAM entry base into staging bytes 0 to 2. Control bit 3 copies RAM entries base to base+4 into all fifteen staging bytes. Staging bytes outside the transfer are left as they were.
- R6: A control write with any of bits 0 to 3 set raises busy for exactly the next cycle, and the command executes in that cycle. Bits 0 to 3 then read back as 0. A control write with bits 0 to 3 all zero starts nothing. Bits 7 to 4 keep the value last written to them.
- R7: When more than one of bits 0 to 3 is set, only the lowest-numbered set bit is executed.
- R8: A command is ignored and sets error when base plus its length exceeds the RAM depth. The length is 1 for a single transfer and 5 for a set. The next command that is in range clears error.
- R9: Host writes to any register are ignored in the cycle when busy is 1.
- R10: A datapath read is taken on an edge where dpRdEn and dpRdReady are both 1. The RAM word then appears on dpRdData, with dpRdValid, in the following cycle. dpRdReady is 0 during a commit cycle, and a read accepted after the commit returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 5 | Host register address |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Combinational read of the register at hostAddr |
| dpRdEn | input | 1 | Datapath read request |
| dpRdAddr | input | 6 | Datapath read coefficient index |
| dpRdReady | output | 1 | Low while a commit is in progress |
| dpRdValid | output | 1 | dpRdData holds the word for the read accepted last cycle |
| dpRdData | output | 24 | Coefficient word |

## Verification
The bench targets the last legal set base (59) and the first illegal one (60). A design with an off-by-one range check would either corrupt the top entries or refuse a valid set. It issues control bytes with several command bits set. A wrong priority encoder would then run a read where a write was expected, leaving the RAM stale. It also writes staging and raises a datapath read inside the busy cycle. A design without the busy guard would overwrite staging. A design without the stall would hand out the pre-commit word or a duplicate valid. Random mixes of single and set transfers, each read back over both ports, catch byte-order and coefficient-slot errors.

// File: rtl/coef_stage_pkg.sv
package coef_stage_pkg;
  localparam int SET_LEN = 5;
  localparam int BYTES_PER_COEF = 3;
  localparam int STAGE_BYTES = SET_LEN * BYTES_PER_COEF;
  localparam logic [23:0] UNITY = 24'h7FFFFF;
  localparam logic [4:0] REG_ADDR = 5'd16;
  localparam logic [4:0] REG_CTRL = 5'd17;
  localparam logic [4:0] REG_STAT = 5'd18;

  typedef struct packed {
    logic       commitOne;
    logic       commitSet;
    logic       loadOne;
    logic       loadSet;
    logic [7:0] base;
    logic       stageWr;
    logic [3:0] stageIdx;
    logic [7:0] stageByte;
  } ctlStrobes_t;
endpackage

// File: rtl/coef_stage_ctrl.sv
module coef_stage_ctrl
  import coef_stage_pkg::*;
#(
  parameter int COEF_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [4:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  input  logic [7:0]  stageRdByte,
  output logic [3:0]  stageRdIdx,
  output logic [7:0]  hostRdData,
  output ctlStrobes_t strb
);
  logic       busy;
  logic       errReg;
  logic [7:0] addrReg;
  logic [7:0] ctrlReg;
  logic       acceptWr;
  logic       selWrOne, selWrSet, selRdOne, selRdSet;
  int         cmdLen;
  logic       inRange;

  assign acceptWr = hostWrEn && !busy;

  // lowest-numbered command bit wins
  always_comb begin
    selWrOne = 1'b0;
    selWrSet = 1'b0;
    selRdOne = 1'b0;
    selRdSet = 1'b0;
    cmdLen   = 1;
    if (ctrlReg[0])      selWrOne = 1'b1;
    else if (ctrlReg[1]) begin selWrSet = 1'b1; cmdLen = SET_LEN; end
    else if (ctrlReg[2]) selRdOne = 1'b1;
    else if (ctrlReg[3]) begin selRdSet = 1'b1; cmdLen = SET_LEN; end
    inRange = (int'(addrReg) + cmdLen) <= COEF_DEPTH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      errReg  <= 1'b0;
      addrReg <= '0;
      ctrlReg <= '0;
    end else if (busy) begin
      busy         <= 1'b0;
      ctrlReg[3:0] <= '0;
      errReg       <= !inRange;
    end else if (acceptWr) begin
      if (hostAddr == REG_ADDR) addrReg <= hostWrData;
      if (hostAddr == REG_CTRL) begin
        ctrlReg <= hostWrData;
        busy    <= |hostWrData[3:0];
      end
    end
  end

  always_comb begin
    strb.commitOne = busy && inRange && selWrOne;
    strb.commitSet = busy && inRange && selWrSet;
    strb.loadOne   = busy && inRange && selRdOne;
    strb.loadSet   = busy && inRange && selRdSet;
    strb.base      = addrReg;
    strb.stageWr   = acceptWr && (int'(hostAddr) < STAGE_BYTES);
    strb.stageIdx  = hostAddr[3:0];
    strb.stageByte = hostWrData;
  end

  assign stageRdIdx = hostAddr[3:0];

  always_comb begin
    if (int'(hostAddr) < STAGE_BYTES) hostRdData = stageRdByte;
    else if (hostAddr == REG_ADDR)    hostRdData = addrReg;
    else if (hostAddr == REG_CTRL)    hostRdData = ctrlReg;
    else if (hostAddr == REG_STAT)    hostRdData = {6'b0, errReg, busy};
    else                              hostRdData = 8'h00;
  end

  // R6: a command occupies exactly one busy cycle
  p_busy_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  // R6: reserved nibble changes only through an accepted control write
  p_reserved_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptWr && hostAddr == REG_CTRL) |=> $stable(ctrlReg[7:4]));
  // R7: at most one transfer strobe per cycle
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.commitOne, strb.commitSet, strb.loadOne, strb.loadSet}));
  // R8: a busy cycle that fires no strobe must leave the error flag set
  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(strb.commitOne || strb.commitSet || strb.loadOne || strb.loadSet))
      |=> errReg);
  // R9: no staging write is passed on while busy
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.stageWr);
endmodule

// File: rtl/coef_stage_data.sv
module coef_stage_data
  import coef_stage_pkg::*;
#(
  parameter int COEF_DEPTH = 64,
  parameter int SCALE_LO = 50,
  parameter int SCALE_HI = 55,
  localparam int AW = $clog2(COEF_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic [3:0]    stageRdIdx,
  output logic [7:0]    stageRdByte,
  input  logic          dpRdEn,
  input  logic [AW-1:0] dpRdAddr,
  output logic          dpRdReady,
  output logic          dpRdValid,
  output logic [23:0]   dpRdData
);
  logic [23:0] ram [COEF_DEPTH];
  logic [7:0]  stage [STAGE_BYTES];
  logic [23:0] stWord [SET_LEN];
  logic        commitAny;
  int          baseI;

  assign baseI     = int'(strb.base);
  assign commitAny = strb.commitOne || strb.commitSet;
  assign dpRdReady = !commitAny;

  always_comb begin
    for (int k = 0; k < SET_LEN; k++)
      stWord[k] = {stage[3*k], stage[3*k+1], stage[3*k+2]};
  end

  // all entries of a set land on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < COEF_DEPTH; i++)
        ram[i] <= (i >= SCALE_LO && i <= SCALE_HI) ? UNITY : 24'h0;
    end else begin
      for (int i = 0; i < COEF_DEPTH; i++) begin
        if (strb.commitOne && baseI == i)
          ram[i] <= stWord[0];
        else if (strb.commitSet && i >= baseI && i < baseI + SET_LEN)
          ram[i] <= stWord[3'(i - baseI)];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGE_BYTES; k++) stage[k] <= 8'h00;
    end else if (strb.loadOne) begin
      stage[0] <= ram[AW'(baseI)][23:16];
      stage[1] <= ram[AW'(baseI)][15:8];
      stage[2] <= ram[AW'(baseI)][7:0];
    end else if (strb.loadSet) begin
      for (int k = 0; k < SET_LEN; k++) begin
        stage[3*k]   <= ram[AW'(baseI + k)][23:16];
        stage[3*k+1] <= ram[AW'(baseI + k)][15:8];
        stage[3*k+2] <= ram[AW'(baseI + k)][7:0];
      end
    end else if (strb.stageWr) begin
      stage[strb.stageIdx] <= strb.stageByte;
    end
  end

  assign stageRdByte = (int'(stageRdIdx) < STAGE_BYTES) ? stage[stageRdIdx] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpRdValid <= 1'b0;
      dpRdData  <= '0;
    end else begin
      dpRdValid <= dpRdEn && dpRdReady;
      if (dpRdEn && dpRdReady) dpRdData <= ram[dpRdAddr];
    end
  end

  // R10: accepted read yields valid next cycle, and nothing else does
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dpRdEn && dpRdReady) |=> dpRdValid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(dpRdEn && dpRdReady) |=> !dpRdValid);

  for (genvar gi = 0; gi < COEF_DEPTH; gi++) begin : g_ramChk
    // R4: RAM moves only on a commit strobe
    p_ram_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      !commitAny |=> $stable(ram[gi]));
  end
  for (genvar gk = 0; gk < STAGE_BYTES; gk++) begin : g_stgChk
    // R9: staging moves only on an accepted write or a load
    p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.stageWr || strb.loadOne || strb.loadSet) |=> $stable(stage[gk]));
  end
endmodule

// File: rtl/coef_stage_top.sv
module coef_stage_top
  import coef_stage_pkg::*;
#(
  parameter int COEF_DEPTH = 64,
  parameter int SCALE_LO = 50,
  parameter int SCALE_HI = 55,
  localparam int AW = $clog2(COEF_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [4:0]    hostAddr,
  input  logic [7:0]    hostWrData,
  output logic [7:0]    hostRdData,
  input  logic          dpRdEn,
  input  logic [AW-1:0] dpRdAddr,
  output logic          dpRdReady,
  output logic          dpRdValid,
  output logic [23:0]   dpRdData
);
  ctlStrobes_t strb;
  logic [3:0]  stageRdIdx;
  logic [7:0]  stageRdByte;

  coef_stage_ctrl #(.COEF_DEPTH(COEF_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .stageRdByte(stageRdByte), .stageRdIdx(stageRdIdx),
    .hostRdData(hostRdData), .strb(strb)
  );

  coef_stage_data #(.COEF_DEPTH(COEF_DEPTH), .SCALE_LO(SCALE_LO), .SCALE_HI(SCALE_HI)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .stageRdIdx(stageRdIdx),
    .stageRdByte(stageRdByte), .dpRdEn(dpRdEn), .dpRdAddr(dpRdAddr),
    .dpRdReady(dpRdReady), .dpRdValid(dpRdValid), .dpRdData(dpRdData)
  );
endmodule

// File: tb/coef_stage_top_test.sv
`timescale 1ns/1ps
module coef_stage_top_test;
  localparam int DEPTH = 64;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        dpRdEn = 1'b0;
  logic [5:0]  dpRdAddr = '0;
  logic        dpRdReady, dpRdValid;
  logic [23:0] dpRdData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  logic [23:0] mRam [DEPTH];
  logic [7:0]  mStage [15];

  always #2 clk = ~clk;

  coef_stage_top uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .dpRdEn(dpRdEn),
    .dpRdAddr(dpRdAddr), .dpRdReady(dpRdReady), .dpRdValid(dpRdValid),
    .dpRdData(dpRdData)
  );

  function automatic logic [23:0] resetVal(int i);
    return (i >= 50 && i <= 55) ? 24'h7FFFFF : 24'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #0.5 d = hostRdData;
  endtask

  task automatic dpRead(int a, output logic [23:0] d, output logic v);
    @(negedge clk);
    dpRdEn = 1'b1; dpRdAddr = 6'(a);
    @(negedge clk);
    dpRdEn = 1'b0;
    d = dpRdData; v = dpRdValid;
  endtask

  task automatic checkRam(string tag, int a);
    logic [23:0] d; logic v;
    dpRead(a, d, v);
    check({tag, " valid"}, 32'(v), 32'd1);
    check(tag, 32'(d), 32'(mRam[a]));
  endtask

  task automatic checkStage(string tag);
    logic [7:0] d;
    for (int k = 0; k < 15; k++) begin
      hostRead(5'(k), d);
      check(tag, 32'(d), 32'(mStage[k]));
    end
  endtask

  task automatic fillStage(int n);
    for (int k = 0; k < n; k++) begin
      mStage[k] = 8'($urandom);
      hostWrite(5'(k), mStage[k]);
    end
  endtask

  // issues a command, waits out the busy cycle, updates the model
  task automatic runCmd(int base, logic [7:0] ctl);
    int len; bit ok;
    hostWrite(5'd16, 8'(base));
    hostWrite(5'd17, ctl);
    @(negedge clk);
    len = (ctl[0] || ctl[2] || !ctl[1] && !ctl[3]) ? 1 : 5;
    if (ctl[0]) len = 1; else if (ctl[1]) len = 5; else if (ctl[2]) len = 1; else len = 5;
    ok = (base + len) <= DEPTH;
    if (ok && ctl[3:0] != 0) begin
      for (int k = 0; k < len; k++) begin
        if (ctl[0] || ctl[1])
          mRam[base+k] = {mStage[3*k], mStage[3*k+1], mStage[3*k+2]};
        else
          {mStage[3*k], mStage[3*k+1], mStage[3*k+2]} = mRam[base+k];
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b; logic [23:0] d; logic v;
    int seed;
    seed = $urandom(32'd17);
    for (int i = 0; i < DEPTH; i++) mRam[i] = resetVal(i);
    for (int k = 0; k < 15; k++) mStage[k] = 8'h00;
    #9 rstN = 1'b1;

    // R1: reset contents
    checkRam("R1 ram0", 0);  checkRam("R1 ram49", 49);
    checkRam("R1 ram50", 50); checkRam("R1 ram55", 55);
    checkRam("R1 ram56", 56); checkRam("R1 ram63", 63);
    checkStage("R1 stage");
    hostRead(5'd16, b); check("R1 addr", 32'(b), 0);
    hostRead(5'd17, b); check("R1 ctrl", 32'(b), 0);
    hostRead(5'd18, b); check("R1 status", 32'(b), 0);
    hostRead(5'd20, b); check("R2 unused addr", 32'(b), 0);

    // R3: single write, MSB first
    mStage[0] = 8'h12; mStage[1] = 8'h34; mStage[2] = 8'h56;
    for (int k = 0; k < 3; k++) hostWrite(5'(k), mStage[k]);
    runCmd(7, 8'h01);
    checkRam("R3 single write", 7);
    check("R3 word order", 32'(mRam[7]), 32'h123456);
    hostRead(5'd17, b); check("R6 selfclear", 32'(b), 0);
    hostRead(5'd18, b); check("R6 idle status", 32'(b), 0);

    // R4 / R2: set at last legal base
    fillStage(15);
    runCmd(59, 8'h02);
    for (int k = 0; k < 5; k++) checkRam("R4 set write", 59 + k);
    hostRead(5'd18, b); check("R8 no error at 59", 32'(b), 0);

    // R8: first illegal base
    fillStage(15);
    runCmd(60, 8'h02);
    hostRead(5'd18, b); check("R8 error set", 32'(b), 32'h2);
    for (int k = 60; k < 64; k++) checkRam("R8 untouched", k);
    runCmd(200, 8'h04);
    hostRead(5'd18, b); check("R8 single out of range", 32'(b), 32'h2);
    checkStage("R8 stage untouched");
    runCmd(0, 8'h01);
    hostRead(5'd18, b); check("R8 error cleared", 32'(b), 0);
    checkRam("R8 in range write", 0);

    // R5: single and set reads
    fillStage(15);
    runCmd(59, 8'h04);
    checkStage("R5 single read");
    runCmd(50, 8'h08);
    checkStage("R5 set read");

    // R6: reserved bits kept, zero command does nothing
    fillStage(3);
    runCmd(9, 8'hA1);
    hostRead(5'd17, b); check("R6 reserved kept", 32'(b), 32'hA0);
    checkRam("R6 cmd with reserved", 9);
    hostWrite(5'd17, 8'h50);
    hostRead(5'd18, b); check("R6 zero cmd not busy", 32'(b), 0);
    hostRead(5'd17, b); check("R6 ctrl 0x50", 32'(b), 32'h50);
    checkStage("R6 zero cmd stage");

    // R7: lowest bit wins
    fillStage(15);
    runCmd(20, 8'h06);
    for (int k = 0; k < 5; k++) checkRam("R7 write beats read", 20 + k);
    checkStage("R7 stage after write");
    fillStage(15);
    runCmd(30, 8'h0C);
    checkStage("R7 single read beats set read");

    // R9 / R10: writes and datapath reads during busy
    mStage[0] = 8'hAB; mStage[1] = 8'hCD; mStage[2] = 8'hEF;
    for (int k = 0; k < 3; k++) hostWrite(5'(k), mStage[k]);
    hostWrite(5'd16, 8'd12);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 5'd17; hostWrData = 8'h01;
    @(negedge clk);
    hostWrData = 8'hEE; hostAddr = 5'd0;
    dpRdEn = 1'b1; dpRdAddr = 6'd12;
    #0.5 check("R10 ready low in commit", 32'(dpRdReady), 0);
    @(negedge clk);
    hostWrEn = 1'b0;
    mRam[12] = 24'hABCDEF;
    check("R10 no valid while stalled", 32'(dpRdValid), 0);
    @(negedge clk);
    dpRdEn = 1'b0;
    check("R10 valid after stall", 32'(dpRdValid), 1);
    check("R10 new value", 32'(dpRdData), 32'hABCDEF);
    hostRead(5'd0, b); check("R9 busy write ignored", 32'(b), 32'hAB);
    hostRead(5'd17, b); check("R9 ctrl not rewritten", 32'(b), 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op; int base;
      op = int'($urandom_range(0, 3));
      base = (op == 1 || op == 3) ? int'($urandom_range(0, DEPTH - 5)) : int'($urandom_range(0, DEPTH - 1));
      case (op)
        0: begin fillStage(3); runCmd(base, 8'h01); checkRam("R3 random", base); end
        1: begin fillStage(15); runCmd(base, 8'h02);
                 for (int k = 0; k < 5; k++) checkRam("R4 random", base + k); end
        2: begin runCmd(base, 8'h04); checkStage("R5 random single"); end
        default: begin runCmd(base, 8'h08); checkStage("R5 random set"); end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule